// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. Four pins drive it: a test clock, a mode-select input, a serial data input and a serial data output. A sixteen-state controller tracks the standard test-port sequence. A four-bit instruction register chooses which data path sits between serial-in and serial-out: a one-bit bypass stage, a 32-bit identification word, or an external boundary chain. The boundary chain is reached through a serial port with capture, shift and update strobes.

Several instructions also act on the device's outputs. One forces every output driver to high impedance. One holds the boundary cells on their preloaded values. One sends a single-cycle reset pulse to the logic outside the scan chain. A build-time option reproduces a known restart anomaly: after a pause in a data scan, the next bit comes out twice.

Top module: `scan_port_ctrl`

## Requirements
- R1: Five consecutive test-clock rising edges with mode-select high reach Test-Logic-Reset from any state, and they cause no non-scan reset pulse.
- R2: In Test-Logic-Reset the active instruction becomes 1011 (identification). The high-impedance and clamp outputs are deasserted there.
- R3: The identification word is {revision[3:0], part code[15:0], vendor[10:0], 1'b1}. With the defaults it is 32'h0C001069. Part selector values 0, 1 and 2 give part codes C001h, C002h and C092h.
- R4: Capture-IR loads 0001 into the instruction shift stage. That stage shifts least significant bit first. A shifted code changes the active instruction only at Update-IR, on the falling clock edge.
- R5: Code 1111, and every code not listed in R6 to R9 or R2, selects the bypass stage. The bypass stage captures 0 in Capture-DR and delays serial data by one bit.
- R6: Codes 0000 and 1000 select the boundary path. In Capture-DR, Shift-DR and Update-DR the matching strobe is high. Serial-out then returns the boundary serial input, and the boundary serial output follows serial-in.
- R7: Code 0111 asserts the high-impedance output and selects the bypass stage.
- R8: Code 0100 asserts the clamp output and selects the bypass stage.
- R9: Code 1100 selects the bypass stage. It gives a non-scan reset pulse exactly one test-clock cycle long, in the cycle after Update-IR.
- R10: Serial-out changes on the falling clock edge. Its enable is high only while the controller is in Shift-DR or Shift-IR.
- R11: With the quirk option set, resuming Shift-DR from Exit2-DR suppresses one shift, so the next bit appears twice. With the option clear, resuming continues the bit order unchanged.
- R12: At most one boundary strobe is high at a time, and no boundary strobe is high unless code 0000 or 1000 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| tdo_en | output | 1 | Serial-out driver enable |
| bnd_si | output | 1 | Serial data to the boundary chain |
| bnd_so | input | 1 | Serial data from the boundary chain |
| bnd_capture | output | 1 | Boundary capture strobe |
| bnd_shift | output | 1 | Boundary shift strobe |
| bnd_update | output | 1 | Boundary update strobe |
| drivers_hiz | output | 1 | Forces device output drivers to high impedance |
| clamp_en | output | 1 | Holds boundary outputs on preloaded values |
| nonscan_rst | output | 1 | Single-cycle reset pulse for non-scan logic |

## Verification
The bench steps the port through a mode-select reset from inside Shift-DR while high impedance is active. A controller with a wrong transition would stay in the shift state, and the high-impedance output would stay set. It reads the identification word out of two builds with different part selectors, and pauses a scan in each. A swapped delay or an unconditional shift suppression would show as a missing or extra repeated bit. It also loads a reserved code and the bypass code and checks for the one-bit delay with a leading zero. It checks the reset pulse both for its one-cycle width and for staying low during a mode-select reset.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_TLR    = 4'd0,
        ST_RTI    = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SHF_DR = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PAU_DR = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SHF_IR = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PAU_IR = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b1000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b1011;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0111;
    localparam logic [IR_W-1:0] OP_CLAMP   = 4'b0100;
    localparam logic [IR_W-1:0] OP_NSRST   = 4'b1100;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {
        PATH_BYP = 2'd0,
        PATH_ID  = 2'd1,
        PATH_BND = 2'd2
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     hiz;
        logic     clamp;
        logic     nsrst;
    } ir_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic ir_ctl_t ir_decode(input logic [IR_W-1:0] op);
        ir_ctl_t c;
        c.path  = PATH_BYP;
        c.hiz   = 1'b0;
        c.clamp = 1'b0;
        c.nsrst = 1'b0;
        case (op)
            OP_EXTEST, OP_SAMPLE: c.path  = PATH_BND;
            OP_IDCODE:            c.path  = PATH_ID;
            OP_HIGHZ:             c.hiz   = 1'b1;
            OP_CLAMP:             c.clamp = 1'b1;
            OP_NSRST:             c.nsrst = 1'b1;
            default:              c.path  = PATH_BYP;
        endcase
        return c;
    endfunction

    function automatic logic [15:0] part_code(input int unsigned sel);
        case (sel)
            1:       return 16'hC002;
            2:       return 16'hC092;
            default: return 16'hC001;
        endcase
    endfunction

    function automatic logic [ID_W-1:0] id_word(input logic [3:0] rev,
                                                input int unsigned sel,
                                                input logic [10:0] vendor);
        return {rev, part_code(sel), vendor, 1'b1};
    endfunction

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= ST_TLR;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/scan_port_ir.sv
module scan_port_ir
    import scan_port_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_q
);
    logic [IR_W-1:0] sr_q;

    always_ff @(posedge tck) begin
        if (rst)                    sr_q <= IR_CAPTURE;
        else if (state == ST_CAP_IR) sr_q <= IR_CAPTURE;
        else if (state == ST_SHF_IR) sr_q <= {tdi, sr_q[IR_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (rst || state == ST_TLR)  ir_q <= OP_IDCODE;
        else if (state == ST_UPD_IR) ir_q <= sr_q;
    end

    assign ir_so = sr_q[0];
endmodule

// File: rtl/scan_port_dr.sv
module scan_port_dr
    import scan_port_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE    = 32'h0C001069,
    parameter bit              PAUSE_QUIRK = 1'b0
) (
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  dr_path_e   path,
    input  logic       tdi,
    input  logic       bnd_so,
    output logic       dr_so,
    output logic       bnd_capture,
    output logic       bnd_shift,
    output logic       bnd_update
);
    logic            byp_q;
    logic [ID_W-1:0] id_q;
    logic            resumed_q;
    logic            shift_ok;

    always_ff @(posedge tck) begin
        if (rst) resumed_q <= 1'b0;
        else     resumed_q <= (state == ST_EX2_DR);
    end

    generate
        if (PAUSE_QUIRK) begin : g_quirk
            assign shift_ok = (state == ST_SHF_DR) && !resumed_q;
        end else begin : g_strict
            assign shift_ok = (state == ST_SHF_DR);
        end
    endgenerate

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_q  <= ID_VALUE;
        end else begin
            if (state == ST_CAP_DR && path == PATH_BYP)      byp_q <= 1'b0;
            else if (shift_ok && path == PATH_BYP)           byp_q <= tdi;
            if (state == ST_CAP_DR && path == PATH_ID)       id_q <= ID_VALUE;
            else if (shift_ok && path == PATH_ID)            id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    assign bnd_capture = (state == ST_CAP_DR) && (path == PATH_BND);
    assign bnd_shift   = shift_ok && (path == PATH_BND);
    assign bnd_update  = (state == ST_UPD_DR) && (path == PATH_BND);

    always_comb begin
        case (path)
            PATH_ID:  dr_so = id_q[0];
            PATH_BND: dr_so = bnd_so;
            default:  dr_so = byp_q;
        endcase
    end
endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_port_pkg::*;
#(
    parameter int unsigned PART_SEL    = 0,
    parameter logic [3:0]  REVISION    = 4'h0,
    parameter logic [10:0] VENDOR      = 11'h034,
    parameter bit          PAUSE_QUIRK = 1'b0
) (
    input  logic tck,
    input  logic rst,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    output logic bnd_si,
    input  logic bnd_so,
    output logic bnd_capture,
    output logic bnd_shift,
    output logic bnd_update,
    output logic drivers_hiz,
    output logic clamp_en,
    output logic nonscan_rst
);
    localparam logic [ID_W-1:0] ID_VALUE = id_word(REVISION, PART_SEL, VENDOR);

    tap_state_e      state_q;
    logic [IR_W-1:0] ir_q;
    logic            ir_so;
    logic            dr_so;
    ir_ctl_t         ctl;

    scan_port_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state_q)
    );

    scan_port_ir u_ir (
        .tck   (tck),
        .rst   (rst),
        .state (state_q),
        .tdi   (tdi),
        .ir_so (ir_so),
        .ir_q  (ir_q)
    );

    assign ctl = ir_decode(ir_q);

    scan_port_dr #(
        .ID_VALUE    (ID_VALUE),
        .PAUSE_QUIRK (PAUSE_QUIRK)
    ) u_dr (
        .tck         (tck),
        .rst         (rst),
        .state       (state_q),
        .path        (ctl.path),
        .tdi         (tdi),
        .bnd_so      (bnd_so),
        .dr_so       (dr_so),
        .bnd_capture (bnd_capture),
        .bnd_shift   (bnd_shift),
        .bnd_update  (bnd_update)
    );

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state_q == ST_SHF_DR) || (state_q == ST_SHF_IR);
            tdo    <= (state_q == ST_SHF_IR) ? ir_so : dr_so;
        end
    end

    always_ff @(posedge tck) begin
        if (rst) nonscan_rst <= 1'b0;
        else     nonscan_rst <= (state_q == ST_UPD_IR) && ctl.nsrst;
    end

    assign bnd_si      = tdi;
    assign drivers_hiz = ctl.hiz;
    assign clamp_en    = ctl.clamp;
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
    import scan_port_pkg::*;
(
    input logic            tck,
    input logic            rst,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir,
    input logic            tdo_en,
    input logic            bnd_capture,
    input logic            bnd_shift,
    input logic            bnd_update,
    input logic            drivers_hiz,
    input logic            clamp_en,
    input logic            nonscan_rst
);
    logic [2:0] ones_q;

    always_ff @(posedge tck) begin
        if (rst)              ones_q <= 3'd0;
        else if (!tms)        ones_q <= 3'd0;
        else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
    end

    AST_TMS_RESET: assert property (@(posedge tck) disable iff (rst)
        (ones_q == 3'd5) |-> (state == ST_TLR)); // R1

    AST_TLR_CLEARS: assert property (@(posedge tck) disable iff (rst)
        (state == ST_TLR && $past(state) == ST_TLR) |-> (ir == OP_IDCODE && !drivers_hiz && !clamp_en)); // R2

    AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (rst)
        tdo_en == (state == ST_SHF_DR || state == ST_SHF_IR)); // R10

    AST_NSRST_PULSE: assert property (@(posedge tck) disable iff (rst)
        nonscan_rst |=> !nonscan_rst); // R9

    AST_STROBE_ONEHOT: assert property (@(posedge tck) disable iff (rst)
        $onehot0({bnd_capture, bnd_shift, bnd_update})); // R12

    AST_STROBE_BND_ONLY: assert property (@(posedge tck) disable iff (rst)
        (bnd_capture || bnd_shift || bnd_update) |-> (ir == OP_EXTEST || ir == OP_SAMPLE)); // R12

    AST_HIZ_CLAMP_EXCL: assert property (@(posedge tck) disable iff (rst)
        !(drivers_hiz && clamp_en)); // R7
endmodule

bind scan_port_ctrl scan_port_chk u_chk (
    .tck         (tck),
    .rst         (rst),
    .tms         (tms),
    .state       (state_q),
    .ir          (ir_q),
    .tdo_en      (tdo_en),
    .bnd_capture (bnd_capture),
    .bnd_shift   (bnd_shift),
    .bnd_update  (bnd_update),
    .drivers_hiz (drivers_hiz),
    .clamp_en    (clamp_en),
    .nonscan_rst (nonscan_rst)
);

// File: tb/scan_port_ctrl_bench.sv
`timescale 1ns/1ps
module scan_port_ctrl_bench;

    localparam logic [31:0] ID_A    = 32'h0C001069;
    localparam logic [31:0] ID_B    = 32'h0C092069;
    localparam logic [7:0]  BND_PAT = 8'hA5;

    logic tck = 1'b0;
    logic rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_en, bnd_si, bnd_so, bnd_capture, bnd_shift, bnd_update;
    logic drivers_hiz, clamp_en, nonscan_rst;
    logic q_tdo, q_tdo_en, q_bnd_si, q_bcap, q_bshf, q_bupd, q_hiz, q_clamp, q_nsrst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic first_en;

    logic [7:0] bmodel;
    int         upd_count = 0;

    always #5 tck = ~tck;

    scan_port_ctrl u_scan_port_ctrl (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .bnd_si(bnd_si), .bnd_so(bnd_so), .bnd_capture(bnd_capture),
        .bnd_shift(bnd_shift), .bnd_update(bnd_update),
        .drivers_hiz(drivers_hiz), .clamp_en(clamp_en), .nonscan_rst(nonscan_rst)
    );

    scan_port_ctrl #(.PART_SEL(2), .PAUSE_QUIRK(1'b1)) u_scan_port_ctrl_quirk (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(q_tdo), .tdo_en(q_tdo_en),
        .bnd_si(q_bnd_si), .bnd_so(1'b0), .bnd_capture(q_bcap),
        .bnd_shift(q_bshf), .bnd_update(q_bupd),
        .drivers_hiz(q_hiz), .clamp_en(q_clamp), .nonscan_rst(q_nsrst)
    );

    always_ff @(posedge tck) begin
        if (bnd_capture)    bmodel <= BND_PAT;
        else if (bnd_shift) bmodel <= {bnd_si, bmodel[7:1]};
        if (bnd_update)     upd_count <= upd_count + 1;
    end
    assign bnd_so = bmodel[0];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din,
                           output logic [31:0] dout, output logic [31:0] qout);
        dout = '0;
        qout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        first_en = tdo_en;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            qout[i] = q_tdo;
            step(i == n - 1, din[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_ir(input logic [3:0] din, output logic [3:0] dout, output logic pre_hiz);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            dout[i] = tdo;
            step(i == 3, din[i]);
        end
        pre_hiz = drivers_hiz;
        step(1, 0); step(0, 0);
    endtask

    task automatic t_reset;
        logic [31:0] a, b;
        chk("R10 enable low after reset", {31'd0, tdo_en}, 32'd0);
        chk("R2 hiz low after reset", {31'd0, drivers_hiz}, 32'd0);
        chk("R2 clamp low after reset", {31'd0, clamp_en}, 32'd0);
        chk("R9 no pulse after reset", {31'd0, nonscan_rst}, 32'd0);
        step(0, 0);
        chk("R10 enable low in idle", {31'd0, tdo_en}, 32'd0);
        scan_dr(32, 32'h0, a, b);
        chk("R10 enable high in shift", {31'd0, first_en}, 32'd1);
        chk("R3 default id word", a, ID_A);
        chk("R3 part selector 2 id word", b, ID_B);
    endtask

    task automatic t_ir_capture;
        logic [3:0] o; logic ph; logic [31:0] a, b;
        scan_ir(4'b0111, o, ph);
        chk("R4 capture pattern 0001", {28'd0, o}, 32'd1);
        chk("R4 no effect before update", {31'd0, ph}, 32'd0);
        chk("R7 hiz after update", {31'd0, drivers_hiz}, 32'd1);
        chk("R7 clamp stays low", {31'd0, clamp_en}, 32'd0);
        scan_dr(8, 32'h000000C6, a, b);
        chk("R7 bypass path", a[7:0], 32'h8C);
    endtask

    task automatic t_bypass(input logic [3:0] op, input string req);
        logic [3:0] o; logic ph; logic [31:0] a, b;
        scan_ir(op, o, ph);
        scan_dr(8, 32'h0000005B, a, b);
        chk(req, a[7:0], 32'hB6);
        chk("R12 no boundary update", upd_count, 0);
    endtask

    task automatic t_clamp;
        logic [3:0] o; logic ph; logic [31:0] a, b;
        scan_ir(4'b0100, o, ph);
        chk("R8 clamp asserted", {31'd0, clamp_en}, 32'd1);
        chk("R8 hiz low", {31'd0, drivers_hiz}, 32'd0);
        scan_dr(8, 32'h00000081, a, b);
        chk("R8 bypass path", a[7:0], 32'h02);
    endtask

    task automatic t_nsrst;
        logic [3:0] o; logic ph; logic [31:0] a, b;
        scan_ir(4'b1100, o, ph);
        chk("R9 pulse after update", {31'd0, nonscan_rst}, 32'd1);
        step(0, 0);
        chk("R9 pulse one cycle", {31'd0, nonscan_rst}, 32'd0);
        scan_dr(8, 32'h00000003, a, b);
        chk("R9 bypass path", a[7:0], 32'h06);
    endtask

    task automatic t_boundary(input logic [3:0] op, input string req);
        logic [3:0] o; logic ph; logic [31:0] a, b;
        int u0;
        scan_ir(op, o, ph);
        u0 = upd_count;
        scan_dr(8, 32'h0000003C, a, b);
        chk(req, a[7:0], {24'd0, BND_PAT});
        chk("R6 chain shifted in", {24'd0, bmodel}, 32'h3C);
        chk("R6 one update strobe", upd_count - u0, 1);
    endtask

    task automatic t_tms_reset;
        logic [3:0] o; logic ph; logic [31:0] a, b;
        logic saw;
        scan_ir(4'b0111, o, ph);
        step(1, 0); step(0, 0); step(0, 0);
        saw = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step(1, 0);
            saw = saw | nonscan_rst;
        end
        chk("R1 no pulse on tms reset", {31'd0, saw}, 32'd0);
        chk("R2 hiz cleared", {31'd0, drivers_hiz}, 32'd0);
        chk("R1 enable low after reset", {31'd0, tdo_en}, 32'd0);
        step(0, 0);
        scan_dr(32, 32'h0, a, b);
        chk("R2 id selected after tms reset", a, ID_A);
    endtask

    task automatic t_pause;
        logic [7:0] c, q, ec, eq;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            c[i] = tdo; q[i] = q_tdo;
            step(i == 2, 0);
        end
        step(0, 0); step(1, 0); step(0, 0);
        for (int i = 3; i < 8; i++) begin
            c[i] = tdo; q[i] = q_tdo;
            step(i == 7, 0);
        end
        step(1, 0); step(0, 0);
        for (int i = 0; i < 8; i++) begin
            ec[i] = ID_A[i];
            eq[i] = (i <= 3) ? ID_B[i] : ID_B[i-1];
        end
        chk("R11 compliant resume order", {24'd0, c}, {24'd0, ec});
        chk("R11 quirk repeats bit", {24'd0, q}, {24'd0, eq});
    endtask

    initial begin
        repeat (3) @(negedge tck);
        #1;
        rst = 1'b0;
        t_reset();
        t_ir_capture();
        t_bypass(4'b1111, "R5 bypass code");
        t_bypass(4'b0011, "R5 reserved code bypass");
        t_clamp();
        t_nsrst();
        t_boundary(4'b0000, "R6 extest boundary path");
        t_boundary(4'b1000, "R6 sample boundary path");
        t_tms_reset();
        t_pause();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule